// File: doc/BRIEF.md
# Read/Write Request Arbiter

This block sits between two inbound request streams, one carrying reads and one carrying writes, and a single downstream port that can take one request per cycle. Each stream lands in its own small queue. Every cycle the downstream port signals that it can accept, the arbiter picks one queue head and issues it through a registered output stage. The pick follows a 2-bit policy input: reads first, writes first, or alternation between the two.

A global enable gates all traffic. While it is low, inbound handshakes still complete but the requests are thrown away, nothing is issued, and returning read responses and write commits are not passed on. Each queue asserts a full flag, and withdraws its ready, once its occupancy reaches a programmable watermark, so upstream is held back before the storage is physically exhausted. A busy output reports queued, issuing or outstanding work. A synchronous software reset returns everything to the empty state without touching the hardware reset.

Top module: `rw_arbiter`

## Requirements
- R1: With `mode` = 2'b10, a queued read is always chosen over a queued write; writes are issued only when the read queue is empty.
- R2: With `mode` = 2'b01, a queued write is always chosen over a queued read.
- R3: With `mode` = 2'b00 or 2'b11, when both queues hold requests, the side not chosen by the previous grant wins; after either reset the read side wins the first such tie.
- R4: A grant happens only in a cycle where `dn_ready` is 1 and `enable` is 1; the granted request appears on `dn_valid`/`dn_write`/`dn_tag` in the following cycle, one request per cycle at most (`dn_write` is 1 for a write, 0 for a read).
- R5: While `enable` is 0, `rd_ready` and `wr_ready` are 1, offered requests are accepted and discarded, no request is issued, and `rsp_out_valid` stays 0; requests stored before `enable` fell are kept and issued once it returns.
- R6: A queue's full flag is 1 when its entry count is at least `watermark` (or equals the queue depth); while enabled, that queue's ready is then 0 and offered requests are not stored. A watermark of 0 keeps the queue full.
- R7: `busy` is 1 while any request is queued, being issued, or issued and not yet answered by a response on `rsp_in_valid`; it is 0 otherwise.
- R8: A cycle with `sw_rst` at 1 empties both queues, clears outstanding work and the output stage, and restores the reset tie order; `busy` and `dn_valid` are 0 in the next cycle.
- R9: Within each queue, requests are issued in arrival order and carry their tag unchanged.
- R10: While enabled, a response offered on `rsp_in_valid` appears on `rsp_out_valid` with the same tag and kind one cycle later.
- R11: A change of `mode` takes effect at the next grant decision and does not alter a request already in the output stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| sw_rst | input | 1 | Synchronous software reset, active high |
| enable | input | 1 | Global traffic enable |
| mode | input | 2 | Policy: 10 reads first, 01 writes first, 00/11 alternate |
| watermark | input | WM_W | Occupancy at which a queue reports full |
| rd_valid | input | 1 | Read request offered |
| rd_ready | output | 1 | Read request accepted |
| rd_tag | input | TAG_W | Read request tag |
| rd_full | output | 1 | Read queue at or above watermark |
| wr_valid | input | 1 | Write request offered |
| wr_ready | output | 1 | Write request accepted |
| wr_tag | input | TAG_W | Write request tag |
| wr_full | output | 1 | Write queue at or above watermark |
| dn_ready | input | 1 | Downstream can take a request next cycle |
| dn_valid | output | 1 | Request issued downstream |
| dn_write | output | 1 | Issued request is a write |
| dn_tag | output | TAG_W | Issued request tag |
| rsp_in_valid | input | 1 | Read response or write commit returning |
| rsp_in_write | input | 1 | Returning item is a write commit |
| rsp_in_tag | input | TAG_W | Returning item tag |
| rsp_out_valid | output | 1 | Forwarded response or commit |
| rsp_out_write | output | 1 | Forwarded item is a write commit |
| rsp_out_tag | output | TAG_W | Forwarded item tag |
| busy | output | 1 | Work queued, issuing or outstanding |

## Verification
The policy is driven with preloaded mixes of reads and writes: equal counts in each mode, an uneven mix under alternation, and one-sided loads where only one queue holds anything. Equal mixes tell strict priority from alternation by the grant order, the uneven mix shows that alternation hands the leftovers to the remaining side, and the one-sided loads show that a priority mode never starves the lone queue. A mode switch between two grants separates decision-time policy from the already registered request, and enable toggled around held and freshly offered requests separates discarding from holding.

// File: rtl/rw_arbiter.sv
module rw_arbiter #(
  parameter int TAG_W = 8,
  parameter int DEPTH = 16,
  parameter int WM_W  = 5,
  parameter int OUT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_rst,
  input  logic             enable,
  input  logic [1:0]       mode,
  input  logic [WM_W-1:0]  watermark,
  input  logic             rd_valid,
  output logic             rd_ready,
  input  logic [TAG_W-1:0] rd_tag,
  output logic             rd_full,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [TAG_W-1:0] wr_tag,
  output logic             wr_full,
  input  logic             dn_ready,
  output logic             dn_valid,
  output logic             dn_write,
  output logic [TAG_W-1:0] dn_tag,
  input  logic             rsp_in_valid,
  input  logic             rsp_in_write,
  input  logic [TAG_W-1:0] rsp_in_tag,
  output logic             rsp_out_valid,
  output logic             rsp_out_write,
  output logic [TAG_W-1:0] rsp_out_tag,
  output logic             busy
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [1:0]                  in_valid, full, push, pop, nonempty;
  logic [1:0][TAG_W-1:0]       in_tag, head;
  logic [1:0][CNT_W-1:0]       cnt_v;
  logic                        last_wr, pick_wr, grant;
  logic [OUT_W-1:0]            out_cnt;

  assign in_valid  = {wr_valid, rd_valid};
  assign in_tag[0] = rd_tag;
  assign in_tag[1] = wr_tag;

  generate
    for (genvar i = 0; i < 2; i++) begin : g_q
      logic [TAG_W-1:0] mem [DEPTH];
      logic [PTR_W-1:0] wp, rp;
      logic [CNT_W-1:0] cnt;

      assign cnt_v[i]    = cnt;
      assign head[i]     = mem[rp];
      assign nonempty[i] = cnt != '0;
      assign full[i]     = (int'(cnt) >= int'(watermark)) || (int'(cnt) == DEPTH);
      assign push[i]     = enable && !sw_rst && in_valid[i] && !full[i];
      assign pop[i]      = grant && (pick_wr == 1'(i));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          wp  <= '0;
          rp  <= '0;
          cnt <= '0;
        end else if (sw_rst) begin
          wp  <= '0;
          rp  <= '0;
          cnt <= '0;
        end else begin
          if (push[i]) wp <= (int'(wp) == DEPTH - 1) ? '0 : wp + 1'b1;
          if (pop[i])  rp <= (int'(rp) == DEPTH - 1) ? '0 : rp + 1'b1;
          cnt <= cnt + CNT_W'(push[i]) - CNT_W'(pop[i]);
        end
      end

      always_ff @(posedge clk) begin
        if (push[i]) mem[wp] <= in_tag[i];
      end
    end
  endgenerate

  assign rd_full  = full[0];
  assign wr_full  = full[1];
  assign rd_ready = !enable || !full[0];
  assign wr_ready = !enable || !full[1];

  always_comb begin
    case (mode)
      2'b10:   pick_wr = !nonempty[0];
      2'b01:   pick_wr = nonempty[1];
      default: pick_wr = nonempty[1] && (!nonempty[0] || !last_wr);
    endcase
  end

  assign grant = enable && !sw_rst && dn_ready && (|nonempty);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_wr       <= 1'b1;
      dn_valid      <= 1'b0;
      dn_write      <= 1'b0;
      dn_tag        <= '0;
      out_cnt       <= '0;
      rsp_out_valid <= 1'b0;
      rsp_out_write <= 1'b0;
      rsp_out_tag   <= '0;
    end else if (sw_rst) begin
      last_wr       <= 1'b1;
      dn_valid      <= 1'b0;
      dn_write      <= 1'b0;
      dn_tag        <= '0;
      out_cnt       <= '0;
      rsp_out_valid <= 1'b0;
      rsp_out_write <= 1'b0;
      rsp_out_tag   <= '0;
    end else begin
      dn_valid <= grant;
      if (grant) begin
        dn_write <= pick_wr;
        dn_tag   <= pick_wr ? head[1] : head[0];
        last_wr  <= pick_wr;
      end
      rsp_out_valid <= rsp_in_valid && enable;
      if (rsp_in_valid) begin
        rsp_out_write <= rsp_in_write;
        rsp_out_tag   <= rsp_in_tag;
      end
      out_cnt <= out_cnt + OUT_W'(dn_valid)
                 - OUT_W'(rsp_in_valid && (out_cnt != '0 || dn_valid));
    end
  end

  assign busy = (|nonempty) || dn_valid || (out_cnt != '0);

endmodule

// File: rtl/rw_arbiter_chk.sv
module rw_arbiter_chk #(
  parameter int CNT_W = 5,
  parameter int WM_W  = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sw_rst,
  input logic             enable,
  input logic [1:0]       mode,
  input logic [WM_W-1:0]  watermark,
  input logic             rd_ready,
  input logic             dn_ready,
  input logic             dn_valid,
  input logic             dn_write,
  input logic             rsp_out_valid,
  input logic             busy,
  input logic [CNT_W-1:0] rd_cnt,
  input logic [CNT_W-1:0] wr_cnt
);

  // R1
  rd_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10 && rd_cnt != '0 && dn_ready && enable && !sw_rst) |=> (dn_valid && !dn_write));

  // R2
  wr_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01 && wr_cnt != '0 && dn_ready && enable && !sw_rst) |=> (dn_valid && dn_write));

  // R3
  rr_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[1] == mode[0] && rd_cnt != '0 && wr_cnt != '0 && dn_ready && enable && !sw_rst
     && dn_valid && dn_write) |=> (dn_valid && !dn_write));

  // R4
  ready_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid |-> $past(dn_ready && enable));

  // R5
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!dn_valid && !rsp_out_valid));

  // R6
  watermark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && int'(rd_cnt) >= int'(watermark)) |-> !rd_ready);

  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && !sw_rst) |=> busy);

  // R8
  soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst |=> (!busy && !dn_valid && rd_cnt == '0 && wr_cnt == '0));

endmodule

bind rw_arbiter rw_arbiter_chk #(.CNT_W(CNT_W), .WM_W(WM_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .enable(enable), .mode(mode),
  .watermark(watermark), .rd_ready(rd_ready), .dn_ready(dn_ready),
  .dn_valid(dn_valid), .dn_write(dn_write), .rsp_out_valid(rsp_out_valid),
  .busy(busy), .rd_cnt(cnt_v[0]), .wr_cnt(cnt_v[1])
);

// File: tb/rw_arbiter_tb_top.sv
`timescale 1ns/1ps
module rw_arbiter_tb_top;
  logic       clk = 1'b0, rst_n = 1'b0, sw_rst = 1'b0, enable = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [4:0] watermark = 5'd8;
  logic       rd_valid = 1'b0, wr_valid = 1'b0, dn_ready = 1'b0;
  logic [7:0] rd_tag = '0, wr_tag = '0, rsp_in_tag = '0;
  logic       rsp_in_valid = 1'b0, rsp_in_write = 1'b0;
  wire        rd_ready, rd_full, wr_ready, wr_full, dn_valid, dn_write;
  wire        rsp_out_valid, rsp_out_write, busy;
  wire [7:0]  dn_tag, rsp_out_tag;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  rw_arbiter dut_i (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .enable(enable), .mode(mode),
    .watermark(watermark), .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_tag(rd_tag),
    .rd_full(rd_full), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_tag(wr_tag),
    .wr_full(wr_full), .dn_ready(dn_ready), .dn_valid(dn_valid), .dn_write(dn_write),
    .dn_tag(dn_tag), .rsp_in_valid(rsp_in_valid), .rsp_in_write(rsp_in_write),
    .rsp_in_tag(rsp_in_tag), .rsp_out_valid(rsp_out_valid),
    .rsp_out_write(rsp_out_write), .rsp_out_tag(rsp_out_tag), .busy(busy)
  );

  // {mode, reads, writes, dn_write per grant, first grant in bit 0}
  localparam logic [13:0] VEC [6] = '{
    {2'b10, 3'd3, 3'd3, 6'b111000},
    {2'b01, 3'd3, 3'd3, 6'b000111},
    {2'b00, 3'd3, 3'd3, 6'b101010},
    {2'b11, 3'd2, 3'd4, 6'b111010},
    {2'b10, 3'd0, 3'd2, 6'b000011},
    {2'b00, 3'd4, 3'd0, 6'b000000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input bit wr, input logic [7:0] t);
    if (wr) begin wr_valid = 1'b1; wr_tag = t; end
    else    begin rd_valid = 1'b1; rd_tag = t; end
    @(negedge clk);
    rd_valid = 1'b0;
    wr_valid = 1'b0;
  endtask

  task automatic respond(input bit wr, input logic [7:0] t);
    rsp_in_valid = 1'b1; rsp_in_write = wr; rsp_in_tag = t;
    @(negedge clk);
    rsp_in_valid = 1'b0;
  endtask

  task automatic soft_reset;
    sw_rst = 1'b1;
    @(negedge clk);
    sw_rst = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    logic [1:0] m;
    int nr, nw, ri, wi, seen;
    logic [5:0] pat;
    string req;

    repeat (3) @(negedge clk);
    chk("R8 busy in reset", busy, 0);
    chk("R8 dn_valid in reset", dn_valid, 0);
    chk("R10 rsp_out_valid in reset", rsp_out_valid, 0);
    rst_n = 1'b1; enable = 1'b1;
    @(negedge clk);
    chk("R6 rd_ready after reset", rd_ready, 1);

    for (int v = 0; v < 6; v++) begin
      m = VEC[v][13:12]; nr = int'(VEC[v][11:9]); nw = int'(VEC[v][8:6]); pat = VEC[v][5:0];
      req = (m == 2'b10) ? "R1" : (m == 2'b01) ? "R2" : "R3";
      soft_reset;
      chk("R8 idle after soft reset", busy, 0);
      mode = m;
      for (int k = 0; k < nr; k++) push(1'b0, 8'h10 + 8'(k));
      for (int k = 0; k < nw; k++) push(1'b1, 8'h80 + 8'(k));
      dn_ready = 1'b1; ri = 0; wi = 0;
      for (int g = 0; g < nr + nw; g++) begin
        @(negedge clk);
        chk({req, " grant valid"}, dn_valid, 1);
        chk({req, " grant kind"}, dn_write, pat[g]);
        if (dn_write) begin chk("R9 write tag order", dn_tag, 8'h80 + 8'(wi)); wi++; end
        else          begin chk("R9 read tag order",  dn_tag, 8'h10 + 8'(ri)); ri++; end
      end
      dn_ready = 1'b0;
      @(negedge clk);
      chk("R4 no issue after drain", dn_valid, 0);
    end

    // R4 and R11
    soft_reset;
    mode = 2'b00;
    push(1'b0, 8'h21);
    repeat (3) begin @(negedge clk); chk("R4 held without ready", dn_valid, 0); end
    mode = 2'b10;
    push(1'b1, 8'h91); push(1'b1, 8'h92); push(1'b0, 8'h22);
    dn_ready = 1'b1;
    @(negedge clk);
    chk("R1 read first", dn_write, 0);
    chk("R9 read tag", dn_tag, 8'h21);
    mode = 2'b01;
    #1;
    chk("R11 issued kind kept", dn_write, 0);
    chk("R11 issued tag kept", dn_tag, 8'h21);
    @(negedge clk); chk("R11 new mode applied", dn_write, 1); chk("R9 write tag", dn_tag, 8'h91);
    @(negedge clk); chk("R2 write first", dn_write, 1); chk("R9 write tag", dn_tag, 8'h92);
    @(negedge clk); chk("R2 read last", dn_write, 0); chk("R9 read tag", dn_tag, 8'h22);
    dn_ready = 1'b0;
    @(negedge clk);
    chk("R7 busy with outstanding", busy, 1);
    respond(1'b1, 8'h5A);
    chk("R10 forward valid", rsp_out_valid, 1);
    chk("R10 forward tag", rsp_out_tag, 8'h5A);
    chk("R10 forward kind", rsp_out_write, 1);
    respond(1'b0, 8'h01);
    respond(1'b0, 8'h02);
    chk("R7 busy with one outstanding", busy, 1);
    respond(1'b1, 8'h03);
    chk("R7 idle after last response", busy, 0);

    // R6
    soft_reset;
    watermark = 5'd3; mode = 2'b00;
    push(1'b0, 8'h31); push(1'b0, 8'h32); push(1'b0, 8'h33);
    chk("R6 rd_full at watermark", rd_full, 1);
    chk("R6 rd_ready low at watermark", rd_ready, 0);
    chk("R6 wr_ready unaffected", wr_ready, 1);
    chk("R6 wr_full unaffected", wr_full, 0);
    push(1'b0, 8'h34);
    dn_ready = 1'b1; seen = 0;
    repeat (5) begin @(negedge clk); if (dn_valid) seen++; end
    chk("R6 blocked request not stored", seen, 3);
    dn_ready = 1'b0;

    // R8 with work in flight
    push(1'b1, 8'hA1); push(1'b0, 8'hA2);
    chk("R7 busy before soft reset", busy, 1);
    soft_reset;
    chk("R8 idle after soft reset", busy, 0);
    dn_ready = 1'b1;
    repeat (2) begin @(negedge clk); chk("R8 queues emptied", dn_valid, 0); end

    // R5
    watermark = 5'd0; enable = 1'b0;
    #1;
    chk("R5 ready while disabled", rd_ready, 1);
    chk("R6 watermark zero keeps full", rd_full, 1);
    push(1'b0, 8'h55);
    chk("R5 disabled request not stored", busy, 0);
    respond(1'b0, 8'h77);
    chk("R5 response dropped", rsp_out_valid, 0);
    watermark = 5'd8; enable = 1'b1;
    repeat (3) begin @(negedge clk); chk("R5 dropped request never issued", dn_valid, 0); end
    dn_ready = 1'b0;
    push(1'b0, 8'h66);
    enable = 1'b0; dn_ready = 1'b1;
    repeat (2) begin @(negedge clk); chk("R5 no issue while disabled", dn_valid, 0); end
    chk("R5 stored request held", busy, 1);
    enable = 1'b1;
    @(negedge clk);
    chk("R5 held request issued", dn_valid, 1);
    chk("R5 held request tag", dn_tag, 8'h66);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule